// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one DMA channel. It moves a block of bytes from a source to a destination without processor involvement. Either side may be a memory, or at most one of them may be the single I/O device attached to the channel. Software sets the source and destination addresses, the total byte count, the unit size, per-side increment and I/O flags, and the transfer mode. It then pulses `start`. A configuration the channel cannot run is refused with an error flag, and no bus activity follows.

Each unit is one read cycle from the source on a request/ready bus port, then one write cycle of the held data to the destination. Before the first unit of each request the channel asks for the bus and waits for an external grant. The `ack` line goes to the I/O device and clears the pending request at its source. In single mode `ack` pulses after every unit and the channel waits for a fresh request. In continuous mode one request drives all units back to back, and `ack` pulses only once, after the byte count reaches zero.

Top module: `dma_chan_seq`

## Requirements
- R1: A start with both `cfgSrcIo` and `cfgDstIo` set raises `cfgErr`, leaves `busy` low and starts no bus cycle.
- R2: A start whose size code is 3 (codes 0/1/2 mean 1/2/4 bytes), whose byte count is zero, or whose byte count is not a multiple of the unit size raises `cfgErr` and starts no bus cycle.
- R3: Each unit is a read (`busWrite`=0) at the source address followed by a write (`busWrite`=1) of the data read, at the destination address, with `busSize` equal to the size code. Address and direction hold steady until `busReady`.
- R4: Before the first bus cycle after a request, `busReq` is raised, and no bus cycle begins until `busGrant` has been seen high.
- R5: After each unit the byte count drops by the unit size. A side's address advances by the unit size when its increment flag is set and it is not the I/O side, and stays fixed otherwise. The transfer runs count/size units in total.
- R6: In single mode `ack` is a one-cycle pulse after every unit. The channel starts no bus cycle while `xferReq` is low.
- R7: In continuous mode a single request runs every unit without further requests, and `ack` pulses exactly once, after the last unit.
- R8: When the count reaches zero, `done` is set and `busy` falls. `done` stays set until the next accepted start clears it.
- R9: A `start` pulse while `busy` is high is ignored, and the running transfer finishes with its original configuration.
- R10: An accepted start clears `cfgErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Load configuration and enable |
| cfgSrcAddr | input | ADDR_W | Source start address |
| cfgDstAddr | input | ADDR_W | Destination start address |
| cfgByteCount | input | CNT_W | Total bytes to move |
| cfgSize | input | 2 | Unit size code |
| cfgSrcIo | input | 1 | Source is the I/O device |
| cfgDstIo | input | 1 | Destination is the I/O device |
| cfgSrcInc | input | 1 | Source address increments |
| cfgDstInc | input | 1 | Destination address increments |
| cfgContinuous | input | 1 | 1 = continuous mode, 0 = single mode |
| xferReq | input | 1 | Transfer request from the request source |
| busGrant | input | 1 | Bus ownership granted |
| busReq | output | 1 | Bus ownership requested |
| busValid | output | 1 | Bus cycle active |
| busWrite | output | 1 | 1 = write cycle |
| busAddr | output | ADDR_W | Bus address |
| busSize | output | 2 | Access size code |
| busWdata | output | DATA_W | Write data |
| busRdata | input | DATA_W | Read data |
| busReady | input | 1 | Cycle completes this edge |
| ack | output | 1 | Acknowledge to the I/O device and request source |
| busy | output | 1 | Channel enabled and running |
| done | output | 1 | Terminal count reached |
| cfgErr | output | 1 | Last start refused |

## Verification
Random runs cover all three unit sizes, byte counts of 1 to 12 units, every legal I/O and increment combination, and both modes. Read data is derived from the address, so a wrong address, a skipped unit or stale held data shows up as a mismatch in the logged write. Bus ready and grant arrive after random delays, and in single mode requests are re-raised only after random gaps. This separates handshake stalls from request waits and catches a cycle that starts without a request. Directed cases cover I/O on both sides, size code 3, zero and misaligned counts, a start during a run, and error recovery.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } unit_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_REQ,
    ST_ARB,
    ST_READ,
    ST_WRITE,
    ST_ACK
  } seq_state_e;

  typedef struct packed {
    logic load;
    logic capture;
    logic advance;
    logic selDst;
  } ctrl_strobes_t;

  function automatic logic [2:0] unitBytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: unitBytes = 3'd1;
      SZ_HALF: unitBytes = 3'd2;
      SZ_WORD: unitBytes = 3'd4;
      default: unitBytes = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] loadVal,
  input  logic              step,
  input  logic              stepEn,
  input  logic [2:0]        stepBytes,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0;
    end else if (load) begin
      addr <= loadVal;
    end else if (step && stepEn) begin
      addr <= addr + ADDR_W'(stepBytes);
    end
  end
endmodule

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strb,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [CNT_W-1:0]  cfgByteCount,
  input  logic [1:0]        cfgSize,
  input  logic              cfgSrcIo,
  input  logic              cfgDstIo,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [1:0]        busSize,
  output logic              lastUnit,
  output logic              cfgBad
);
  localparam int NSIDE = 2;

  logic [1:0]        sizeQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] holdQ;
  logic [NSIDE-1:0]  incQ;
  logic [NSIDE-1:0]  ioQ;
  logic [2:0]        stepBytes;
  logic [2:0]        cfgBytes;
  logic [ADDR_W-1:0] sideAddr [NSIDE];
  logic [ADDR_W-1:0] sideInit [NSIDE];

  assign stepBytes = unitBytes(sizeQ);
  assign cfgBytes  = unitBytes(cfgSize);
  assign sideInit[0] = cfgSrcAddr;
  assign sideInit[1] = cfgDstAddr;

  // Refuse: two I/O sides, bad size code, empty or misaligned count
  always_comb begin
    cfgBad = 1'b0;
    if (cfgSrcIo && cfgDstIo)           cfgBad = 1'b1;
    if (cfgSize == SZ_BAD)              cfgBad = 1'b1;
    if (cfgByteCount == '0)             cfgBad = 1'b1;
    if ((cfgByteCount & CNT_W'(cfgBytes - 3'd1)) != '0) cfgBad = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ <= '0;
      cntQ  <= '0;
      incQ  <= '0;
      ioQ   <= '0;
    end else if (strb.load) begin
      sizeQ <= cfgSize;
      cntQ  <= cfgByteCount;
      incQ  <= {cfgDstInc, cfgSrcInc};
      ioQ   <= {cfgDstIo, cfgSrcIo};
    end else if (strb.advance) begin
      cntQ  <= cntQ - CNT_W'(stepBytes);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (strb.capture) begin
      holdQ <= busRdata;
    end
  end

  // One address register per side; index 0 source, 1 destination
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strb.load),
      .loadVal  (sideInit[s]),
      .step     (strb.advance),
      .stepEn   (incQ[s] && !ioQ[s]),
      .stepBytes(stepBytes),
      .addr     (sideAddr[s])
    );
  end

  assign busAddr  = strb.selDst ? sideAddr[1] : sideAddr[0];
  assign busWdata = holdQ;
  assign busSize  = sizeQ;
  assign lastUnit = (cntQ == CNT_W'(stepBytes));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          cfgContinuous,
  input  logic          cfgBad,
  input  logic          lastUnit,
  input  logic          xferReq,
  input  logic          busGrant,
  input  logic          busReady,
  output ctrl_strobes_t strb,
  output logic          busReq,
  output logic          busValid,
  output logic          busWrite,
  output logic          ack,
  output logic          busy,
  output logic          done,
  output logic          cfgErr
);
  seq_state_e stateQ, stateD;
  logic       contQ;
  logic       accept;

  assign accept = (stateQ == ST_IDLE) && start && !cfgBad;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:     if (accept) stateD = ST_WAIT_REQ;
      ST_WAIT_REQ: if (xferReq) stateD = ST_ARB;
      ST_ARB:      if (busGrant) stateD = ST_READ;
      ST_READ:     if (busReady) stateD = ST_WRITE;
      ST_WRITE:    if (busReady) stateD = (contQ && !lastUnit) ? ST_READ : ST_ACK;
      ST_ACK:      stateD = done ? ST_IDLE : ST_WAIT_REQ;
      default:     stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.load    = accept;
    strb.capture = (stateQ == ST_READ) && busReady;
    strb.advance = (stateQ == ST_WRITE) && busReady;
    strb.selDst  = (stateQ == ST_WRITE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      contQ  <= 1'b0;
      done   <= 1'b0;
      cfgErr <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE && start) begin
        if (cfgBad) begin
          cfgErr <= 1'b1;
        end else begin
          cfgErr <= 1'b0;
          done   <= 1'b0;
          contQ  <= cfgContinuous;
        end
      end
      if (strb.advance && lastUnit) done <= 1'b1;
    end
  end

  assign busReq   = (stateQ == ST_ARB) || (stateQ == ST_READ) || (stateQ == ST_WRITE);
  assign busValid = (stateQ == ST_READ) || (stateQ == ST_WRITE);
  assign busWrite = (stateQ == ST_WRITE);
  assign ack      = (stateQ == ST_ACK);
  assign busy     = (stateQ != ST_IDLE);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [CNT_W-1:0]  cfgByteCount,
  input  logic [1:0]        cfgSize,
  input  logic              cfgSrcIo,
  input  logic              cfgDstIo,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic              cfgContinuous,
  input  logic              xferReq,
  input  logic              busGrant,
  output logic              busReq,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              ack,
  output logic              busy,
  output logic              done,
  output logic              cfgErr
);
  ctrl_strobes_t strb;
  logic          lastUnit;
  logic          cfgBad;

  dma_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .cfgContinuous(cfgContinuous),
    .cfgBad       (cfgBad),
    .lastUnit     (lastUnit),
    .xferReq      (xferReq),
    .busGrant     (busGrant),
    .busReady     (busReady),
    .strb         (strb),
    .busReq       (busReq),
    .busValid     (busValid),
    .busWrite     (busWrite),
    .ack          (ack),
    .busy         (busy),
    .done         (done),
    .cfgErr       (cfgErr)
  );

  dma_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgSrcAddr  (cfgSrcAddr),
    .cfgDstAddr  (cfgDstAddr),
    .cfgByteCount(cfgByteCount),
    .cfgSize     (cfgSize),
    .cfgSrcIo    (cfgSrcIo),
    .cfgDstIo    (cfgDstIo),
    .cfgSrcInc   (cfgSrcInc),
    .cfgDstInc   (cfgDstInc),
    .busRdata    (busRdata),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busSize     (busSize),
    .lastUnit    (lastUnit),
    .cfgBad      (cfgBad)
  );
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              cfgSrcIo,
  input logic              cfgDstIo,
  input logic              busGrant,
  input logic              busReq,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busReady,
  input logic              ack,
  input logic              busy,
  input logic              done,
  input logic              cfgErr
);
  p_io_pair_refused_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && cfgSrcIo && cfgDstIo) |=> (cfgErr && !busy));

  p_err_keeps_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!busy && !busValid));

  p_hold_until_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busWrite)));

  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busReady) |=> (busValid && busWrite));

  p_grant_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busValid) |-> ($past(busGrant) && $past(busReq)));

  p_ack_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> (!ack && !busValid));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !busy) |-> (!busValid && !busReq));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cfgSrcAddr = '0, cfgDstAddr = '0;
  logic [CW-1:0] cfgByteCount = '0;
  logic [1:0]    cfgSize = '0;
  logic          cfgSrcIo = 0, cfgDstIo = 0, cfgSrcInc = 0, cfgDstInc = 0, cfgContinuous = 0;
  logic          xferReq = 0, busGrant = 0, busReady = 0;
  logic [DW-1:0] busRdata = '0;
  logic          busReq, busValid, busWrite, ack, busy, done, cfgErr;
  logic [AW-1:0] busAddr;
  logic [1:0]    busSize;
  logic [DW-1:0] busWdata;

  always #2.5 clk = ~clk;

  dma_chan_seq u0 (.*);

  int nChk = 0, nFail = 0;
  int nLog = 0, ackCount = 0;
  logic [AW-1:0] logAddr [64];
  logic [DW-1:0] logData [64];
  logic          logWr   [64];
  logic [1:0]    logSz   [64];
  logic          reqArm = 0, tbCont = 0, grantSeen = 0;
  int            gap = 0;
  logic [AW-1:0] pAddr;
  logic [DW-1:0] pData;
  logic          pWr;
  logic [1:0]    pSz;

  function automatic logic [DW-1:0] memVal(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory / I/O responder and bus logger
  initial forever begin
    @(negedge clk);
    if (busReady) begin
      if (nLog < 64) begin
        logAddr[nLog] = pAddr; logData[nLog] = pData; logWr[nLog] = pWr; logSz[nLog] = pSz;
      end
      nLog++;
      busReady = 0;
    end else if (busValid && ($urandom % 2 == 0)) begin
      pAddr = busAddr; pWr = busWrite; pSz = busSize;
      pData = busWrite ? busWdata : memVal(busAddr);
      if (!busWrite) busRdata = memVal(busAddr);
      busReady = 1;
    end
  end

  // Grant agent: R4 no bus cycle before a grant
  initial forever begin
    @(negedge clk);
    if (busValid && !grantSeen) check(1'b0, "R4 bus cycle without grant", 1, 0);
    busGrant = busReq ? (busGrant | ($urandom % 2 == 0)) : 1'b0;
    if (!busReq) grantSeen = 0;
    else if (busGrant) grantSeen = 1;
  end

  // Request agent: R6 no cycle while request low in single mode
  initial forever begin
    @(negedge clk);
    if (!tbCont && busValid && !xferReq) check(1'b0, "R6 bus cycle without request", 0, 1);
    if (ack) begin
      ackCount++;
      xferReq = 0;
      gap = $urandom % 4;
    end else if (!xferReq && reqArm) begin
      if (gap > 0) gap--;
      else begin
        xferReq = 1;
        if (tbCont) reqArm = 0;
      end
    end else if (xferReq && tbCont && busValid) begin
      xferReq = 0;
    end
  end

  task automatic setCfg(input logic [AW-1:0] s, input logic [AW-1:0] d, input int cnt, input int sz,
                        input logic sIo, input logic dIo, input logic sInc, input logic dInc, input logic cont);
    cfgSrcAddr = s; cfgDstAddr = d; cfgByteCount = CW'(cnt); cfgSize = 2'(sz);
    cfgSrcIo = sIo; cfgDstIo = dIo; cfgSrcInc = sInc; cfgDstInc = dInc; cfgContinuous = cont;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic runGood(input logic [AW-1:0] s, input logic [AW-1:0] d, input int cnt, input int sz,
                         input logic sIo, input logic dIo, input logic sInc, input logic dInc,
                         input logic cont, input logic poke);
    int units, bytes, waitC;
    logic [AW-1:0] sE, dE;
    logic ok;
    bytes = 1 << sz;
    units = cnt / bytes;
    nLog = 0; ackCount = 0; tbCont = cont;
    setCfg(s, d, cnt, sz, sIo, dIo, sInc, dInc, cont);
    gap = $urandom % 3; reqArm = 1;
    pulseStart();
    check(done == 0 && cfgErr == 0 && busy == 1, "R8/R10 start clears done and error", {done, cfgErr, busy}, 3'b001);
    if (poke) begin
      repeat (3) @(negedge clk);
      setCfg(s ^ 32'h0F00, d ^ 32'h00F0, bytes, sz, 0, 0, 1, 1, ~cont);
      start = 1; @(negedge clk); start = 0;
      setCfg(s, d, cnt, sz, sIo, dIo, sInc, dInc, cont);
    end
    waitC = 0;
    while (!done && waitC < 3000) begin @(negedge clk); waitC++; end
    check(done == 1, "R8 done at terminal count", done, 1);
    repeat (2) @(negedge clk);
    reqArm = 0; xferReq = 0;
    check(busy == 0, "R8 busy falls after last unit", busy, 0);
    check(nLog == 2 * units, "R5 unit count", nLog, 2 * units);
    ok = 1;
    for (int i = 0; i < units && 2 * i + 1 < 64; i++) begin
      sE = (sIo || !sInc) ? s : s + AW'(i * bytes);
      dE = (dIo || !dInc) ? d : d + AW'(i * bytes);
      if (logWr[2*i] !== 0 || logAddr[2*i] !== sE || logSz[2*i] !== 2'(sz)) begin
        ok = 0; check(0, "R3/R5 read cycle", logAddr[2*i], sE);
      end
      if (logWr[2*i+1] !== 1 || logAddr[2*i+1] !== dE || logData[2*i+1] !== memVal(sE) || logSz[2*i+1] !== 2'(sz)) begin
        ok = 0; check(0, "R3/R5 write cycle", {logAddr[2*i+1], logData[2*i+1]}, {dE, memVal(sE)});
      end
    end
    check(ok, poke ? "R9 start during run ignored" : "R3 unit sequence", ok, 1);
    if (cont) check(ackCount == 1, "R7 single ack in continuous mode", ackCount, 1);
    else      check(ackCount == units, "R6 ack per unit in single mode", ackCount, units);
    @(negedge clk);
    check(done == 1, "R8 done holds until next start", done, 1);
  endtask

  task automatic runBad(input int cnt, input int sz, input logic sIo, input logic dIo, input string req);
    nLog = 0;
    setCfg(32'h100, 32'h200, cnt, sz, sIo, dIo, 1, 1, 0);
    reqArm = 1; tbCont = 0;
    pulseStart();
    repeat (8) @(negedge clk);
    reqArm = 0; xferReq = 0;
    check(cfgErr == 1 && busy == 0 && nLog == 0, req, {cfgErr, busy, nLog[7:0]}, 10'h200);
  endtask

  initial begin
    int sz, units, c;
    logic sIo, dIo;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && cfgErr == 0 && ack == 0 && busValid == 0 && busReq == 0,
          "R8 reset state", {busy, done, cfgErr, ack, busValid, busReq}, 0);
    rstN = 1;
    @(negedge clk);
    runBad(8, 2, 1, 1, "R1 both sides I/O refused");
    runGood(32'h1000, 32'h2000, 8, 2, 0, 0, 1, 1, 0, 0);
    check(cfgErr == 0, "R10 valid start cleared error", cfgErr, 0);
    runBad(8, 3, 0, 0, "R2 size code 3 refused");
    runBad(0, 0, 0, 0, "R2 zero count refused");
    runBad(6, 2, 0, 0, "R2 misaligned count refused");
    runBad(3, 1, 0, 1, "R2 odd count with halfwords refused");
    runGood(32'h3000, 32'h4000, 12, 1, 1, 0, 1, 1, 1, 0);
    runGood(32'h5000, 32'h6000, 5, 0, 0, 1, 1, 1, 0, 0);
    runGood(32'h7000, 32'h8000, 4, 2, 0, 0, 1, 1, 1, 0);
    runGood(32'h9000, 32'hA000, 16, 2, 0, 0, 1, 0, 0, 1);
    runGood(32'hB000, 32'hC000, 24, 2, 0, 0, 1, 1, 1, 1);
    for (int k = 0; k < 20; k++) begin
      sz = $urandom % 3;
      units = 1 + $urandom % 12;
      c = $urandom % 3;
      sIo = (c == 1); dIo = (c == 2);
      runGood($urandom & 32'hFFF0, $urandom & 32'hFFF0, units << sz, sz, sIo, dIo,
              1'($urandom), 1'($urandom), 1'($urandom), 0);
    end
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule